// File: doc/BRIEF.md
# Cross-Domain Station Address Register Bank

This block keeps a bank of 48-bit station addresses that software programs over a 32-bit host register bus, and hands each one to a separate line clock domain that feeds the transmit and receive paths. Each entry is written as two words. The high word carries address bits [47:32] in its lower 16 bits. The low word carries bits [31:0].

Writing the high word only stages a value. The staged 48-bit address moves to the line domain when a write to the low word touches one particular byte lane. An endianness input picks that lane: the top lane when it is low and the bottom lane when it is high. On such a write the host side takes a snapshot of the staged address into a launch register and flips a per-entry toggle flag. The line domain passes the toggle through two flip-flops, detects its edge, and on that edge loads the snapshot into its shadow copy.

Host reads return the staged words. The line-side copies appear only on the line ports.

Top module: `station_addr_bank`

## Requirements
- R1: After reset every staged word reads as zero, every line-side copy is zero, and no load pulse is asserted.
- R2: A write to the low word of an entry (entry base offset 0) updates only the byte lanes whose enable bit is set. Lane k is `host_wdata[8k+7:8k]`, and the new value reads back at the same address.
- R3: A write to the high word of an entry (entry base offset 4) updates only lanes 0 and 1 where they are enabled. Bits [31:16] read as zero and ignore writes, and the low word is left unchanged.
- R4: A write to the high word alone leaves the line-side copy and its load pulse unchanged.
- R5: With `big_endian`=0, a low-word write whose enable bit 3 is set moves {high[15:0], low[31:0]}, including the bytes of that same write, into the line copy within 6 line clock cycles.
- R6: With `big_endian`=1, only a low-word write with enable bit 0 set starts a transfer. A low-word write with only enable bit 3 set does not.
- R7: With `big_endian`=0, a low-word write with enable bit 3 clear updates the staged word but starts no transfer.
- R8: Each transfer raises that entry's bit of `line_load` for exactly one line clock cycle. The line copy changes only in the cycle after such a pulse.
- R9: Entry i occupies byte addresses i*ENTRY_STRIDE (low) and i*ENTRY_STRIDE+4 (high). Any other offset, and any entry index of NUM_ENTRIES or more, ignores writes and reads as zero.
- R10: A line copy holds the value staged at its last triggering write. High-word writes made after that write do not reach it until the next triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Host register bus clock |
| host_rst_n | input | 1 | Host-domain asynchronous reset, active low |
| host_wr_en | input | 1 | Write strobe for the current address |
| host_addr | input | ADDR_W | Byte address of the register access |
| host_wdata | input | 32 | Write data |
| host_be | input | 4 | Byte lane enables, bit k for `host_wdata[8k+7:8k]` |
| host_rdata | output | 32 | Staged word at `host_addr`, zero when unmapped |
| big_endian | input | 1 | Selects lane 0 (1) or lane 3 (0) as the transfer trigger |
| line_clk | input | 1 | Line-side clock |
| line_rst_n | input | 1 | Line-domain asynchronous reset, active low |
| line_load | output | NUM_ENTRIES | One-cycle load pulse per entry in the line domain |
| line_addr_flat | output | NUM_ENTRIES*48 | Line-side copies; entry i at bits [48i+47:48i] |

## Verification
The assertions assume that two triggering writes to the same entry are spaced far enough apart that its toggle flag changes at most once in any two line clock cycles. This lets the single-cycle pulse and the stable-launch properties hold. They also assume that `big_endian` is held steady while a write is on the bus. The stimulus spaces every write by at least five host cycles, which at the chosen clock ratio is more than six line cycles. It changes the endianness input only between writes. It runs the line clock at a period unrelated to the host clock, so the toggle crossing is sampled at drifting phases.

// File: rtl/sab_pkg.sv
package sab_pkg;

    localparam int STN_W   = 48;
    localparam int HI_W    = 16;
    localparam int LO_W    = 32;
    localparam int LANES   = 4;

    typedef logic [STN_W-1:0] stn_addr_t;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_LO   = 2'd1,
        REG_HI   = 2'd2
    } reg_kind_e;

    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
        stn_addr_t       launch;
        logic            tog;
    } stage_st_t;

    typedef struct packed {
        logic meta;
        logic sync;
        logic seen;
    } xfer_st_t;

    // Byte lane that starts a transfer for the given endianness
    function automatic logic lane_fires(input logic [LANES-1:0] be, input logic big_endian);
        return big_endian ? be[0] : be[LANES-1];
    endfunction

endpackage

// File: rtl/sab_host_decode.sv
module sab_host_decode #(
    parameter int NUM_ENTRIES  = 4,
    parameter int ADDR_W       = 8,
    parameter int ENTRY_STRIDE = 8
) (
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [NUM_ENTRIES*16-1:0]   stage_hi_flat,
    input  logic [NUM_ENTRIES*32-1:0]   stage_lo_flat,
    output logic [NUM_ENTRIES-1:0]      wr_lo,
    output logic [NUM_ENTRIES-1:0]      wr_hi,
    output logic [31:0]                 rdata
);
    import sab_pkg::*;

    localparam int OFS_W  = $clog2(ENTRY_STRIDE);
    localparam int IDX_W  = ADDR_W - OFS_W;
    localparam int HI_OFS = 4;

    logic [OFS_W-1:0] ofs;
    logic [IDX_W-1:0] idx;
    reg_kind_e        kind;

    always_comb begin
        ofs  = addr[OFS_W-1:0];
        idx  = addr[ADDR_W-1:OFS_W];
        kind = REG_NONE;
        if (int'(idx) < NUM_ENTRIES) begin
            if (ofs == '0)
                kind = REG_LO;
            else if (ofs == OFS_W'(HI_OFS))
                kind = REG_HI;
        end
    end

    always_comb begin
        wr_lo = '0;
        wr_hi = '0;
        rdata = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (idx == IDX_W'(i)) begin
                wr_lo[i] = wr_en && (kind == REG_LO);
                wr_hi[i] = wr_en && (kind == REG_HI);
                if (kind == REG_LO)
                    rdata = stage_lo_flat[i*32 +: 32];
                else if (kind == REG_HI)
                    rdata = {16'h0000, stage_hi_flat[i*16 +: 16]};
            end
        end
    end

    // R9: at most one register is targeted by any write
    always_comb begin
        a_r9_one_target: assert ($onehot0({wr_lo, wr_hi}));
    end

endmodule

// File: rtl/sab_entry_stage.sv
module sab_entry_stage (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        big_endian,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic [3:0]  be,
    output logic [15:0] stage_hi,
    output logic [31:0] stage_lo,
    output logic [47:0] launch,
    output logic        tog
);
    import sab_pkg::*;

    stage_st_t st_d, st_q;
    logic      fire;

    always_comb begin
        st_d = st_q;
        fire = wr_lo && lane_fires(be, big_endian);
        if (wr_hi) begin
            for (int k = 0; k < 2; k++) begin
                if (be[k])
                    st_d.hi[k*8 +: 8] = wdata[k*8 +: 8];
            end
        end
        if (wr_lo) begin
            for (int k = 0; k < LANES; k++) begin
                if (be[k])
                    st_d.lo[k*8 +: 8] = wdata[k*8 +: 8];
            end
        end
        if (fire) begin
            st_d.launch = {st_d.hi, st_d.lo};
            st_d.tog    = ~st_q.tog;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign stage_hi = st_q.hi;
    assign stage_lo = st_q.lo;
    assign launch   = st_q.launch;
    assign tog      = st_q.tog;

    // R5 / R6: a triggering low write flips the request toggle
    a_r5_trigger_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && (big_endian ? be[0] : be[3])) |=> (tog != $past(tog)));

    // R7: a low write missing the trigger lane leaves the toggle alone
    a_r7_no_lane_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !(big_endian ? be[0] : be[3])) |=> $stable(tog));

    // R4: a high-word write never flips the toggle
    a_r4_high_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> $stable(tog));

    // R10: the launch snapshot changes only on a triggering write
    a_r10_launch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo && (big_endian ? be[0] : be[3])) |=> $stable(launch));

    // R3: a high-word write leaves the staged low word alone
    a_r3_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> $stable(stage_lo));

endmodule

// File: rtl/sab_xfer_sync.sv
module sab_xfer_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic load
);
    import sab_pkg::*;

    xfer_st_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = tog_in;
        sy_d.sync = sy_q.meta;
        sy_d.seen = sy_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sy_q <= '0;
        else
            sy_q <= sy_d;
    end

    assign load = sy_q.sync ^ sy_q.seen;

    // R8: each load pulse lasts exactly one line cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

endmodule

// File: rtl/sab_line_copy.sv
module sab_line_copy (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [47:0] launch_in,
    output logic [47:0] shadow
);
    import sab_pkg::*;

    stn_addr_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load)
            sh_d = launch_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_d;
    end

    assign shadow = sh_q;

    // R8: the copy moves only after a load pulse
    a_r8_copy_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(shadow));

    // R10: on a load the copy takes the launched snapshot
    a_r10_copy_takes_launch: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shadow == $past(launch_in)));

endmodule

// File: rtl/station_addr_bank.sv
module station_addr_bank #(
    parameter int NUM_ENTRIES  = 4,
    parameter int ADDR_W       = 8,
    parameter int ENTRY_STRIDE = 8
) (
    input  logic                       host_clk,
    input  logic                       host_rst_n,
    input  logic                       host_wr_en,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [31:0]                host_wdata,
    input  logic [3:0]                 host_be,
    output logic [31:0]                host_rdata,
    input  logic                       big_endian,
    input  logic                       line_clk,
    input  logic                       line_rst_n,
    output logic [NUM_ENTRIES-1:0]     line_load,
    output logic [NUM_ENTRIES*48-1:0]  line_addr_flat
);
    import sab_pkg::*;

    logic [NUM_ENTRIES-1:0]    wr_lo, wr_hi, tog;
    logic [NUM_ENTRIES*16-1:0] hi_flat;
    logic [NUM_ENTRIES*32-1:0] lo_flat;
    logic [NUM_ENTRIES*48-1:0] launch_flat;

    sab_host_decode #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W),
        .ENTRY_STRIDE(ENTRY_STRIDE)
    ) u_decode (
        .wr_en        (host_wr_en),
        .addr         (host_addr),
        .stage_hi_flat(hi_flat),
        .stage_lo_flat(lo_flat),
        .wr_lo        (wr_lo),
        .wr_hi        (wr_hi),
        .rdata        (host_rdata)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        sab_entry_stage u_stage (
            .clk       (host_clk),
            .rst_n     (host_rst_n),
            .big_endian(big_endian),
            .wr_lo     (wr_lo[g]),
            .wr_hi     (wr_hi[g]),
            .wdata     (host_wdata),
            .be        (host_be),
            .stage_hi  (hi_flat[g*16 +: 16]),
            .stage_lo  (lo_flat[g*32 +: 32]),
            .launch    (launch_flat[g*48 +: 48]),
            .tog       (tog[g])
        );

        sab_xfer_sync u_sync (
            .clk   (line_clk),
            .rst_n (line_rst_n),
            .tog_in(tog[g]),
            .load  (line_load[g])
        );

        sab_line_copy u_copy (
            .clk      (line_clk),
            .rst_n    (line_rst_n),
            .load     (line_load[g]),
            .launch_in(launch_flat[g*48 +: 48]),
            .shadow   (line_addr_flat[g*48 +: 48])
        );
    end

endmodule

// File: tb/tb_station_addr_bank.sv
module tb_station_addr_bank;

    localparam int N   = 4;
    localparam int AW  = 8;
    localparam int STR = 8;

    logic hclk = 1'b0;
    logic lclk = 1'b0;
    always #10 hclk = ~hclk;
    initial begin
        #3;
        forever #7 lclk = ~lclk;
    end

    logic            host_rst_n, line_rst_n, host_wr_en, big_endian;
    logic [AW-1:0]   host_addr;
    logic [31:0]     host_wdata, host_rdata;
    logic [3:0]      host_be;
    logic [N-1:0]    line_load;
    logic [N*48-1:0] line_addr_flat;

    station_addr_bank #(.NUM_ENTRIES(N), .ADDR_W(AW), .ENTRY_STRIDE(STR)) dut (
        .host_clk(hclk), .host_rst_n(host_rst_n), .host_wr_en(host_wr_en),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_rdata(host_rdata), .big_endian(big_endian), .line_clk(lclk),
        .line_rst_n(line_rst_n), .line_load(line_load), .line_addr_flat(line_addr_flat)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit chk_on = 0;

    logic [15:0] m_hi [N];
    logic [31:0] m_lo [N];
    logic [47:0] e_cur [N];
    logic [47:0] e_new [N];
    bit          pend [N];
    int          dl [N];
    string       ptag [N];
    int          trig_cnt [N];
    int          pulse_cnt [N];
    bit          prev_load [N];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    // Reference of the line-side copies, compared on every line clock
    always @(negedge lclk) begin
        if (chk_on) begin
            for (int i = 0; i < N; i++) begin
                logic [47:0] got;
                got = line_addr_flat[i*48 +: 48];
                if (line_load[i]) begin
                    pulse_cnt[i]++;
                    check(!prev_load[i], "R8", "load pulse longer than one cycle", 64'(1), 64'(0));
                end
                prev_load[i] = line_load[i];
                if (pend[i]) begin
                    if (got == e_new[i]) begin
                        e_cur[i] = e_new[i];
                        pend[i]  = 0;
                        check(1'b1, ptag[i], "copy arrived", 64'(got), 64'(e_new[i]));
                    end else begin
                        check(got == e_cur[i], ptag[i], "copy changed to wrong value", 64'(got), 64'(e_cur[i]));
                        dl[i]--;
                        if (dl[i] <= 0) begin
                            check(1'b0, ptag[i], "copy late", 64'(got), 64'(e_new[i]));
                            e_cur[i] = e_new[i];
                            pend[i]  = 0;
                        end
                    end
                end else begin
                    check(got == e_cur[i], "R4", "copy changed without trigger", 64'(got), 64'(e_cur[i]));
                end
            end
        end
    end

    task automatic do_write(input logic [AW-1:0] addr, input logic [31:0] data, input logic [3:0] be);
        int idx, ofs;
        @(negedge hclk);
        host_addr  = addr;
        host_wdata = data;
        host_be    = be;
        host_wr_en = 1'b1;
        @(posedge hclk);
        #1;
        idx = int'(addr) / STR;
        ofs = int'(addr) % STR;
        if (idx < N) begin
            if (ofs == 0) begin
                for (int k = 0; k < 4; k++)
                    if (be[k]) m_lo[idx][k*8 +: 8] = data[k*8 +: 8];
                if ((big_endian && be[0]) || (!big_endian && be[3])) begin
                    e_new[idx] = {m_hi[idx], m_lo[idx]};
                    pend[idx]  = 1;
                    dl[idx]    = 6;
                    ptag[idx]  = big_endian ? "R6" : "R5";
                    trig_cnt[idx]++;
                end
            end else if (ofs == 4) begin
                for (int k = 0; k < 2; k++)
                    if (be[k]) m_hi[idx][k*8 +: 8] = data[k*8 +: 8];
            end
        end
        @(negedge hclk);
        host_wr_en = 1'b0;
        repeat (5) @(negedge hclk);
    endtask

    task automatic check_read(input logic [AW-1:0] addr, input logic [31:0] exp, input string tag);
        @(negedge hclk);
        host_addr = addr;
        #2;
        check(host_rdata == exp, tag, "readback", 64'(host_rdata), 64'(exp));
    endtask

    task automatic check_copy(input int i, input logic [47:0] exp, input string tag);
        check(line_addr_flat[i*48 +: 48] == exp, tag, "line copy", 64'(line_addr_flat[i*48 +: 48]), 64'(exp));
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge hclk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        host_rst_n = 0; line_rst_n = 0; host_wr_en = 0; big_endian = 0;
        host_addr = '0; host_wdata = '0; host_be = '0;
        for (int i = 0; i < N; i++) begin
            m_hi[i] = '0; m_lo[i] = '0; e_cur[i] = '0; e_new[i] = '0;
            pend[i] = 0; dl[i] = 0; ptag[i] = "R5"; trig_cnt[i] = 0;
            pulse_cnt[i] = 0; prev_load[i] = 0;
        end
        repeat (3) @(negedge hclk);
        host_rst_n = 1; line_rst_n = 1;
        repeat (2) @(negedge hclk);
        chk_on = 1;

        // R1: reset state
        for (int i = 0; i < N; i++) begin
            check_read(AW'(i*STR), 32'h0, "R1");
            check_read(AW'(i*STR + 4), 32'h0, "R1");
            check_copy(i, 48'h0, "R1");
        end
        check(line_load == '0, "R1", "no load pulse", 64'(line_load), 64'(0));

        // R3: high word takes only its lower two lanes
        do_write(AW'(1*STR + 4), 32'hABCD_1234, 4'hF);
        check_read(AW'(1*STR + 4), 32'h0000_1234, "R3");
        check_copy(1, 48'h0, "R4");

        // R2 / R7: partial low write without lane 3, no transfer
        do_write(AW'(1*STR), 32'h5566_7788, 4'b0111);
        check_read(AW'(1*STR), 32'h0066_7788, "R2");
        check_copy(1, 48'h0, "R7");

        // R5: lane 3 triggers, carries the same write's bytes
        do_write(AW'(1*STR), 32'h9900_0000, 4'b1000);
        check_read(AW'(1*STR), 32'h9966_7788, "R2");
        check_copy(1, 48'h1234_9966_7788, "R5");

        // R3 / R10: partial high write, copy keeps old value
        do_write(AW'(1*STR + 4), 32'hFFFF_5600, 4'b0010);
        check_read(AW'(1*STR + 4), 32'h0000_5634, "R3");
        check_read(AW'(1*STR), 32'h9966_7788, "R3");
        check_copy(1, 48'h1234_9966_7788, "R10");

        // R6: big-endian mode, lane 3 alone no longer triggers
        big_endian = 1;
        do_write(AW'(2*STR + 4), 32'h0000_BEEF, 4'b0011);
        do_write(AW'(2*STR), 32'h1100_0000, 4'b1000);
        check_copy(2, 48'h0, "R6");
        do_write(AW'(2*STR), 32'h0000_0022, 4'b0001);
        check_copy(2, 48'hBEEF_1100_0022, "R6");
        check_read(AW'(2*STR), 32'h1100_0022, "R2");

        // R9: unmapped offset and out-of-range entry
        do_write(AW'(3*STR + 2), 32'hDEAD_BEEF, 4'hF);
        check_read(AW'(3*STR + 2), 32'h0, "R9");
        check_read(AW'(3*STR), 32'h0, "R9");
        do_write(AW'(N*STR), 32'hCAFE_F00D, 4'hF);
        check_read(AW'(N*STR), 32'h0, "R9");
        check_copy(3, 48'h0, "R9");

        // R9 / R5: every entry sits at its own stride
        big_endian = 0;
        for (int i = 0; i < N; i++) begin
            do_write(AW'(i*STR + 4), 32'h0000_A000 | 32'(i), 4'hF);
            do_write(AW'(i*STR), 32'hC0DE_0000 | 32'(i << 4), 4'hF);
        end
        for (int i = 0; i < N; i++) begin
            check_copy(i, {m_hi[i], m_lo[i]}, "R9");
            check_read(AW'(i*STR + 4), {16'h0, m_hi[i]}, "R9");
        end

        // R8: one pulse per transfer
        repeat (4) @(negedge hclk);
        for (int i = 0; i < N; i++)
            check(pulse_cnt[i] == trig_cnt[i], "R8", "pulse count", 64'(pulse_cnt[i]), 64'(trig_cnt[i]));

        done = 1;
        summary();
        $finish;
    end

endmodule